// File: doc/BRIEF.md
# Packed Fixed-Point Multiply Unit

This block is a two-stage pipelined datapath that multiplies packed 16-bit lanes in one of two arithmetic modes. In fractional mode every lane of both operands is a signed Q15 number covering -1.0 up to just below +1.0. Each lane result is the product rounded to the nearest Q15 value. For example, 0x4000 stands for +0.5 and 0xA000 for -0.75.

In byte multiply-accumulate mode each operand lane is split into two bytes. Bytes of operand A are unsigned and bytes of operand B are signed. The two byte products of a lane are added, and the sum is clamped to a signed 16-bit word.

A width select picks a 64-bit or a 128-bit operation. A narrow operation produces only the lower half of the result. A result leaves the unit a fixed number of cycles after its operands enter, and a new operation may enter on every clock.

Top module: `pfx_mul_unit`

## Requirements
- R1: While reset is held and after its release until the first result, out_valid is 0 and out_data is all zero.
- R2: With in_op = 0 (fractional), each 16-bit lane i (bits 16i+15:16i) of the result equals bits 15:0 of ((A_i * B_i) >>> 14) + 1, shifted right arithmetically by one, with A_i and B_i signed; e.g. 0x4000 * 0x4000 gives 0x2000.
- R3: In fractional mode a lane with A_i = B_i = 0x8000 yields 0x8000, the wrapped low 16 bits of the rounded value.
- R4: With in_op = 1 (byte mode), lane i equals a0*b0 + a1*b1, where a0/b0 are bits 16i+7:16i and a1/b1 are bits 16i+15:16i+8, bytes of A unsigned and bytes of B signed.
- R5: In byte mode a lane sum above 32767 gives 0x7FFF and a sum below -32768 gives 0x8000.
- R6: With in_wide = 0 only lanes 0..3 are computed and out_data[127:64] is zero; with in_wide = 1 all eight lanes are computed.
- R7: out_valid is asserted exactly two clock cycles after in_valid, and operations issued on consecutive cycles give results on consecutive cycles.
- R8: When out_valid is 0, out_data is all zero, whatever operand values were driven with in_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| in_op | input | 1 | 0 = rounded Q15 multiply, 1 = byte multiply with pair sum and saturation |
| in_wide | input | 1 | 1 = 128-bit operation, 0 = 64-bit operation |
| in_a | input | 128 | Operand A, eight 16-bit lanes |
| in_b | input | 128 | Operand B, eight 16-bit lanes |
| out_valid | output | 1 | Result is valid this cycle |
| out_data | output | 128 | Packed result |

## Verification
The bench instantiates the unit with its default DATA_W of 128. This gives eight lanes, so a narrow operation leaves four lanes that must stay zero and both halves of the width mask are exercised. Directed operands cover the two Q15 code points, the 0x8000 wrap, and both saturation extremes of byte mode (255 times 127 and 255 times -128 in both byte positions). Random back-to-back traffic with idle gaps shows that every lane is independent and that the latency stays fixed.

// File: rtl/pfx_pkg.sv
// Shared constants and types for the packed fixed-point multiply unit.
// Assumes 16-bit result lanes built from two 8-bit byte positions.
package pfx_pkg;
    localparam int LANE_W = 16;
    localparam int BYTE_W = 8;
    localparam int PROD_W = 2 * LANE_W;      // full Q15 product width
    localparam int BPROD_W = 2 * BYTE_W + 1; // unsigned x signed byte product
    localparam int BSUM_W = BPROD_W + 1;     // sum of two byte products

    typedef enum logic {
        OP_FRAC = 1'b0,
        OP_BYTE = 1'b1
    } pfx_op_e;

    typedef struct packed {
        logic signed [PROD_W-1:0]  frac_p;
        logic signed [BPROD_W-1:0] lo_p;
        logic signed [BPROD_W-1:0] hi_p;
    } lane_prod_t;
endpackage

// File: rtl/pfx_lane_mul.sv
// First-stage lane multiplier: forms the full signed 16x16 product used by
// fractional mode and both unsigned-by-signed byte products used by byte mode.
// Purely combinational; the caller registers the result.
module pfx_lane_mul
    import pfx_pkg::*;
(
    input  logic [LANE_W-1:0] a_lane,
    input  logic [LANE_W-1:0] b_lane,
    output lane_prod_t        prod
);
    logic signed [BPROD_W-1:0] a_lo_ext, a_hi_ext, b_lo_ext, b_hi_ext;

    // Extend the bytes: A zero-extended (unsigned), B sign-extended (signed).
    always_comb begin
        a_lo_ext = $signed({{(BPROD_W-BYTE_W){1'b0}}, a_lane[BYTE_W-1:0]});
        a_hi_ext = $signed({{(BPROD_W-BYTE_W){1'b0}}, a_lane[LANE_W-1:BYTE_W]});
        b_lo_ext = $signed({{(BPROD_W-BYTE_W){b_lane[BYTE_W-1]}}, b_lane[BYTE_W-1:0]});
        b_hi_ext = $signed({{(BPROD_W-BYTE_W){b_lane[LANE_W-1]}}, b_lane[LANE_W-1:BYTE_W]});
    end

    // Form the three products in parallel.
    always_comb begin
        prod.frac_p = PROD_W'($signed(a_lane)) * PROD_W'($signed(b_lane));
        prod.lo_p   = a_lo_ext * b_lo_ext;
        prod.hi_p   = a_hi_ext * b_hi_ext;
    end
endmodule

// File: rtl/pfx_lane_finish.sv
// Second-stage lane finisher: rounds the Q15 product, or sums the two byte
// products and clamps them to a signed 16-bit word, depending on the mode.
// Purely combinational; assumes products from pfx_lane_mul.
module pfx_lane_finish
    import pfx_pkg::*;
(
    input  pfx_op_e           op,
    input  lane_prod_t        prod,
    output logic [LANE_W-1:0] res
);
    localparam int SH_W = PROD_W - (LANE_W - 2);   // bits left after >>> 14
    localparam logic signed [BSUM_W-1:0] SAT_HI = BSUM_W'(32767);
    localparam logic signed [BSUM_W-1:0] SAT_LO = -BSUM_W'(32768);

    logic signed [SH_W-1:0]   rnd;
    logic signed [BSUM_W-1:0] psum;
    logic [LANE_W-1:0]        frac_res, byte_res;

    // Fractional path: drop 14 bits, add the rounding one, drop one more bit.
    always_comb begin
        rnd      = prod.frac_p[PROD_W-1:LANE_W-2] + SH_W'(1);
        frac_res = rnd[LANE_W:1];
    end

    // Byte path: add the sign-extended products and clamp to 16 bits.
    always_comb begin
        psum = BSUM_W'(prod.lo_p) + BSUM_W'(prod.hi_p);
        if (psum > SAT_HI)      byte_res = 16'h7FFF;
        else if (psum < SAT_LO) byte_res = 16'h8000;
        else                    byte_res = psum[LANE_W-1:0];
    end

    // Select the result for the lane's mode.
    always_comb res = (op == OP_BYTE) ? byte_res : frac_res;
endmodule

// File: rtl/pfx_mul_unit.sv
// Packed fixed-point multiply unit, two pipeline stages.
// Stage 1 registers per-lane products; stage 2 registers the finished,
// width-masked result. Assumes DATA_W is a multiple of 32 (two halves of
// whole 16-bit lanes). out_data is held at zero whenever out_valid is low.
module pfx_mul_unit
    import pfx_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_op,
    input  logic              in_wide,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int NLANES = DATA_W / LANE_W;
    localparam int HALF_LANES = NLANES / 2;
    localparam int HALF_W = DATA_W / 2;

    lane_prod_t        prod_c  [NLANES];
    lane_prod_t        prod_s1 [NLANES];
    logic [LANE_W-1:0] fin_c   [NLANES];
    logic [DATA_W-1:0] packed_c;
    logic              vld_s1, wide_s1;
    pfx_op_e           op_s1;

    // Per-lane multipliers and finishers.
    for (genvar li = 0; li < NLANES; li++) begin : g_lane
        pfx_lane_mul u_mul (
            .a_lane (in_a[li*LANE_W +: LANE_W]),
            .b_lane (in_b[li*LANE_W +: LANE_W]),
            .prod   (prod_c[li])
        );

        // Stage-1 product register, loaded only for a valid operation.
        always_ff @(posedge clk) begin
            if (!rst_n)        prod_s1[li] <= '0;
            else if (in_valid) prod_s1[li] <= prod_c[li];
        end

        pfx_lane_finish u_fin (
            .op   (op_s1),
            .prod (prod_s1[li]),
            .res  (fin_c[li])
        );

        // Lanes of the upper half drop out of a narrow operation.
        if (li < HALF_LANES) begin : g_low
            always_comb packed_c[li*LANE_W +: LANE_W] = fin_c[li];
        end else begin : g_high
            always_comb packed_c[li*LANE_W +: LANE_W] = wide_s1 ? fin_c[li] : '0;
        end
    end

    // Stage-1 control register: valid, mode and width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_s1  <= 1'b0;
            op_s1   <= OP_FRAC;
            wide_s1 <= 1'b0;
        end else begin
            vld_s1 <= in_valid;
            if (in_valid) begin
                op_s1   <= pfx_op_e'(in_op);
                wide_s1 <= in_wide;
            end
        end
    end

    // Stage-2 output register; data is zero when no result is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= vld_s1;
            out_data  <= vld_s1 ? packed_c : '0;
        end
    end

    // R7: a result appears exactly two cycles after its operands.
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n)) |-> (out_valid == $past(in_valid, 2)));

    // R6: a narrow operation leaves the upper half of the result at zero.
    assert_narrow_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && !$past(wide_s1)) |-> (out_data[DATA_W-1:HALF_W] == '0));

    // R3: minus one times minus one wraps to 0x8000 in lane 0.
    assert_frac_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && $past(in_valid, 2) && ($past(in_op, 2) == 1'b0)
         && ($past(in_a[15:0], 2) == 16'h8000) && ($past(in_b[15:0], 2) == 16'h8000))
        |-> (out_data[15:0] == 16'h8000));

    // R5: largest positive byte pair sum clamps to 0x7FFF in lane 0.
    assert_sat_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && $past(in_valid, 2) && ($past(in_op, 2) == 1'b1)
         && ($past(in_a[15:0], 2) == 16'hFFFF) && ($past(in_b[15:0], 2) == 16'h7F7F))
        |-> (out_data[15:0] == 16'h7FFF));

    // R8: no result means an all-zero output word.
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0));
endmodule

// File: tb/pfx_mul_unit_test.sv
// Self-checking bench: behavioural reference model with a queue of expected
// outputs, compared against the unit on every clock.
module pfx_mul_unit_test;
    localparam int DW = 128;
    localparam int NL = DW / 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_op, in_wide;
    logic [DW-1:0] in_a, in_b;
    logic          out_valid;
    logic [DW-1:0] out_data;

    typedef struct {
        logic          v;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t expq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pfx_mul_unit #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_wide(in_wide), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [15:0] ref_frac(logic [15:0] a, logic [15:0] b);
        int p, r;
        p = int'($signed(a)) * int'($signed(b));
        r = ((p >>> 14) + 1) >>> 1;
        return r[15:0];
    endfunction

    function automatic logic [15:0] ref_pair(logic [15:0] a, logic [15:0] b);
        int s;
        s = int'(a[7:0]) * int'($signed(b[7:0])) + int'(a[15:8]) * int'($signed(b[15:8]));
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        return s[15:0];
    endfunction

    function automatic logic [DW-1:0] ref_word(logic v, logic op, logic wide,
                                               logic [DW-1:0] a, logic [DW-1:0] b);
        logic [DW-1:0] w = '0;
        if (v) begin
            for (int i = 0; i < NL; i++) begin
                if (wide || i < NL / 2)
                    w[i*16 +: 16] = op ? ref_pair(a[i*16 +: 16], b[i*16 +: 16])
                                       : ref_frac(a[i*16 +: 16], b[i*16 +: 16]);
            end
        end
        return w;
    endfunction

    task automatic check(string tag, logic ev, logic [DW-1:0] ed);
        n_cmp++;
        if (out_valid !== ev || out_data !== ed) begin
            n_bad++;
            $display("FAIL %s: valid %0b data %h, expected valid %0b data %h",
                     tag, out_valid, out_data, ev, ed);
        end
    endtask

    // One cycle: compare the output due now, then drive and predict.
    task automatic step(logic v, logic op, logic wide,
                        logic [DW-1:0] a, logic [DW-1:0] b, string tag);
        exp_t e;
        @(negedge clk);
        if (expq.size() >= 2) begin
            e = expq.pop_front();
            check(e.tag, e.v, e.d);
        end
        in_valid = v; in_op = op; in_wide = wide; in_a = a; in_b = b;
        e.v = v; e.d = ref_word(v, op, wide, a, b); e.tag = tag;
        expq.push_back(e);
    endtask

    function automatic logic [DW-1:0] rnd_word();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        exp_t idle;
        rst_n = 1'b0; in_valid = 1'b0; in_op = 1'b0; in_wide = 1'b0;
        in_a = rnd_word(); in_b = rnd_word();
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, '0);
        rst_n = 1'b1;
        in_a = '0; in_b = '0;
        idle.v = 1'b0; idle.d = '0; idle.tag = "R1 after reset";
        expq.push_back(idle);
        expq.push_back(idle);

        // R2: Q15 code points (0.5*0.5, -0.75*0.5, -0.75*-0.75, 0.5*-1)
        step(1, 0, 1, {16'h4000, 16'hA000, 16'hA000, 16'h4000, 16'h7FFF, 16'h0001, 16'hFFFF, 16'h4000},
                      {16'h4000, 16'h4000, 16'hA000, 16'h8000, 16'h7FFF, 16'h0001, 16'hFFFF, 16'h4000}, "R2 code points");
        // R3: -1 * -1 in every lane
        step(1, 0, 1, {8{16'h8000}}, {8{16'h8000}}, "R3 wrap");
        // R4: ordinary byte sums (unsigned A, signed B)
        step(1, 1, 1, {16'h0102, 16'h80FF, 16'h0010, 16'hFF00, 16'h1234, 16'h00FF, 16'h0203, 16'h0000},
                      {16'h0304, 16'h0101, 16'hFFF0, 16'h80FF, 16'h5678, 16'h00FF, 16'hFEFD, 16'h1111}, "R4 byte sums");
        // R5: clamp to both extremes
        step(1, 1, 1, {{4{16'hFFFF}}, {4{16'hFFFF}}}, {{4{16'h7F7F}}, {4{16'h8080}}}, "R5 saturation");
        // R6: narrow operations in both modes
        step(1, 0, 0, rnd_word(), rnd_word(), "R6 narrow frac");
        step(1, 1, 0, rnd_word(), rnd_word(), "R6 narrow byte");
        // R8: idle cycles with noisy operands
        step(0, 1, 1, rnd_word(), rnd_word(), "R8 idle");
        step(0, 0, 1, rnd_word(), rnd_word(), "R8 idle");
        // R7: back-to-back random traffic with occasional gaps
        for (int k = 0; k < 400; k++) begin
            logic v = ($urandom % 5) != 0;
            step(v, 1'($urandom), 1'($urandom), rnd_word(), rnd_word(), v ? "R7 stream" : "R8 gap");
        end
        // drain
        step(0, 0, 0, '0, '0, "R8 drain");
        step(0, 0, 0, '0, '0, "R8 drain");
        step(0, 0, 0, '0, '0, "R8 drain");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule